// File: doc/BRIEF.md
# Two-Wire Slave Shift Unit with Clock Hold

This block is the low-level serial engine of a slave on a two-wire bus made of an open-drain clock line and an open-drain data line. It watches both lines through synchronizers. It recognises bus start and stop conditions. It shifts incoming data bits into a shift register on rising clock edges and counts every clock edge in a small counter. It can also drive the data line low from a latched copy of the shift register's top bit.

The block makes no protocol decisions of its own. Local firmware decides where bytes and acknowledge bits end by loading the edge counter. The block pulls the clock line low after a start condition and whenever the counter wraps. This stalls the master until firmware has examined the byte, prepared the next one and cleared the matching flag. Address matching, the acknowledge policy and the direction of transfer are all handled by firmware through a small write port. Register contents and flags are visible on dedicated outputs.

Top module: `twi_shift_slave`

## Requirements
- R1: A falling data line while the clock line is high (both seen after synchronization) sets the start flag, and the interrupt request output goes high.
- R2: After a start, the first falling clock edge makes the block drive the clock line low. The clock stays low until firmware writes 1 to status bit 0, which clears the start flag and releases the clock.
- R3: On each rising clock edge the shift register moves one place toward its most significant bit and takes the data line value into bit 0. Eight bits sent MSB first therefore end up as the byte sent.
- R4: The counter increments on both clock edges. When an edge arrives with the counter at all ones, the counter wraps to 0, the overflow flag (status bit 1) is set and the clock line is driven low. Writing 1 to status bit 1 clears the flag and releases the clock.
- R5: A counter preloaded with 14 overflows after exactly one bit period (one rising and one falling edge).
- R6: The data line is driven low only when the output enable (control bit 0) is 1 and the output latch is 0. The latch takes bit 7 of the written value on a data-register write, and takes shift-register bit 7 on each falling clock edge.
- R7: A rising data line while the clock line is high sets the stop flag (status bit 2), releases any clock hold, and cancels a start hold that has not yet engaged.
- R8: The write port decodes addresses as follows: 0 loads the shift register, 1 loads the counter from the low bits, 2 clears status flags (write 1 to clear), and 3 sets control. Set events take priority over clears in the same cycle.
- R9: After reset, both line drivers are released and the flags, counter, shift register and output enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DW | Write data |
| shift_q | output | DW | Shift register contents |
| count_q | output | CW | Edge counter value |
| start_flag_o | output | 1 | Start condition flag |
| ovf_flag_o | output | 1 | Counter overflow flag |
| stop_flag_o | output | 1 | Stop condition flag |
| irq_o | output | 1 | Start or overflow interrupt request |

## Verification
The bench builds the block with its default 8-bit shift register and 4-bit counter, so one full wrap of the counter covers a byte and a preload of 14 covers one acknowledge bit. These sizes allow complete addressed transactions in both directions: address byte, acknowledge driven by the slave, data byte sent by either side, and the closing stop. Transaction bytes are random under a fixed seed, with the all-ones and all-zeros addresses forced as corner cases. A start followed at once by a stop checks that the pending clock hold is cancelled.

// File: rtl/twi_shift_slave.sv
module twi_shift_slave #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_low_o,
  output logic          sda_low_o,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] shift_q,
  output logic [CW-1:0] count_q,
  output logic          start_flag_o,
  output logic          ovf_flag_o,
  output logic          stop_flag_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [1:0] scl_sy, sda_sy;
  logic scl_p, sda_p, scl_s, sda_s;
  logic [DW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic dout, oe;
  logic start_flag, start_arm, hold_start;
  logic ovf_flag, hold_ovf, stop_flag;

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire scl_edge  = scl_rise | scl_fall;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire ovf_evt   = scl_edge & (cnt == CNT_TOP);

  wire wr_data = reg_we && reg_addr == 2'd0;
  wire wr_cnt  = reg_we && reg_addr == 2'd1;
  wire wr_stat = reg_we && reg_addr == 2'd2;
  wire wr_ctl  = reg_we && reg_addr == 2'd3;
  wire clr_start = wr_stat & reg_wdata[0];
  wire clr_ovf   = wr_stat & reg_wdata[1];
  wire clr_stop  = wr_stat & reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      dout  <= 1'b1;
      cnt   <= '0;
      oe    <= 1'b0;
    end else begin
      if (wr_data)       shreg <= reg_wdata;
      else if (scl_rise) shreg <= {shreg[DW-2:0], sda_s};

      if (wr_data)       dout <= reg_wdata[DW-1];
      else if (scl_fall) dout <= shreg[DW-1];

      if (wr_cnt)        cnt <= reg_wdata[CW-1:0];
      else if (scl_edge) cnt <= cnt + 1'b1;

      if (wr_ctl)        oe <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_flag <= 1'b0;
      start_arm  <= 1'b0;
      hold_start <= 1'b0;
      ovf_flag   <= 1'b0;
      hold_ovf   <= 1'b0;
      stop_flag  <= 1'b0;
    end else begin
      if (start_det)      start_flag <= 1'b1;
      else if (clr_start) start_flag <= 1'b0;

      if (start_det)                              start_arm <= 1'b1;
      else if (scl_fall || stop_det || clr_start) start_arm <= 1'b0;

      if (stop_det || clr_start)      hold_start <= 1'b0;
      else if (start_arm && scl_fall) hold_start <= 1'b1;

      if (ovf_evt)      ovf_flag <= 1'b1;
      else if (clr_ovf) ovf_flag <= 1'b0;

      if (ovf_evt)                  hold_ovf <= 1'b1;
      else if (stop_det || clr_ovf) hold_ovf <= 1'b0;

      if (stop_det)      stop_flag <= 1'b1;
      else if (clr_stop) stop_flag <= 1'b0;
    end
  end

  assign scl_low_o    = hold_start | hold_ovf;
  assign sda_low_o    = oe & ~dout;
  assign shift_q      = shreg;
  assign count_q      = cnt;
  assign start_flag_o = start_flag;
  assign ovf_flag_o   = ovf_flag;
  assign stop_flag_o  = stop_flag;
  assign irq_o        = start_flag | ovf_flag;
endmodule

// File: rtl/twi_shift_slave_chk.sv
module twi_shift_slave_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_p,
  input logic          sda_s,
  input logic          sda_p,
  input logic          oe,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          scl_low_o,
  input logic          sda_low_o,
  input logic [DW-1:0] shift_q,
  input logic [CW-1:0] count_q,
  input logic          start_flag_o,
  input logic          ovf_flag_o,
  input logic          stop_flag_o
);
  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_flag_o) |-> $past(scl_s && scl_p && sda_p && !sda_s));

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !scl_p && !(reg_we && reg_addr == 2'd0)) |=> shift_q[0] == $past(sda_s));

  assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> (scl_low_o && count_q == '0));

  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !sda_low_o);

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag_o) |-> !scl_low_o);
endmodule

bind twi_shift_slave twi_shift_slave_chk #(.DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s),
  .sda_p(sda_p), .oe(oe), .reg_we(reg_we), .reg_addr(reg_addr),
  .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .shift_q(shift_q),
  .count_q(count_q), .start_flag_o(start_flag_o), .ovf_flag_o(ovf_flag_o),
  .stop_flag_o(stop_flag_o)
);

// File: tb/twi_shift_slave_tb_top.sv
`timescale 1ns/1ps
module twi_shift_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic scl_low_o, sda_low_o, start_flag_o, ovf_flag_o, stop_flag_o, irq_o;
  logic [7:0] shift_q;
  logic [3:0] count_q;
  wire scl_line = scl_m & ~scl_low_o;
  wire sda_line = sda_m & ~sda_low_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twi_shift_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .shift_q(shift_q),
    .count_q(count_q), .start_flag_o(start_flag_o), .ovf_flag_o(ovf_flag_o),
    .stop_flag_o(stop_flag_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] ack_load();
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    idle(2);
  endtask

  task automatic m_bit(input bit b, output bit r);
    sda_m = b; idle(6);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(6);
    r = sda_line;
    scl_m = 1'b0; idle(6);
  endtask

  task automatic m_start();
    sda_m = 1'b0; idle(6);
    chk(start_flag_o && irq_o, "R1 start flag", {start_flag_o, irq_o}, 3);
    chk(!scl_low_o, "R2 no hold before fall", scl_low_o, 0);
    scl_m = 1'b0; idle(6);
    chk(scl_low_o, "R2 start hold", scl_low_o, 1);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; idle(6);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    idle(6);
    sda_m = 1'b1; idle(6);
    chk(stop_flag_o, "R7 stop flag", stop_flag_o, 1);
    wr(2'd2, 8'h04);
    chk(!stop_flag_o, "R8 stop clear", stop_flag_o, 0);
  endtask

  task automatic slave_ack();
    bit r;
    wr(2'd0, ack_load()); wr(2'd3, 8'h01); wr(2'd1, 8'd14); wr(2'd2, 8'h02);
    chk(sda_low_o, "R6 ack drive", sda_low_o, 1);
    m_bit(1'b1, r);
    chk(r == 1'b0, "R6 ack seen", r, 0);
    chk(ovf_flag_o && scl_low_o && count_q == 0, "R5 ack overflow",
        {ovf_flag_o, scl_low_o, count_q}, 8'h30);
  endtask

  task automatic transaction(input logic [7:0] adr, input logic [7:0] d);
    bit r;
    logic [7:0] got;
    m_start();
    wr(2'd1, 8'h00); wr(2'd2, 8'h01);
    chk(!scl_low_o && !start_flag_o, "R2 release", {scl_low_o, start_flag_o}, 0);
    for (int i = 7; i >= 0; i--) m_bit(adr[i], r);
    chk(shift_q == adr, "R3 address byte", shift_q, adr);
    chk(ovf_flag_o && scl_low_o && irq_o, "R4 byte overflow hold",
        {ovf_flag_o, scl_low_o, irq_o}, 7);
    chk(count_q == 0, "R4 counter wrap", count_q, 0);
    slave_ack();
    if (adr[0]) begin
      wr(2'd0, d); wr(2'd1, 8'h00); wr(2'd2, 8'h02);
      chk(!scl_low_o, "R4 overflow release", scl_low_o, 0);
      for (int i = 7; i >= 0; i--) begin
        m_bit(1'b1, r);
        got[i] = r;
      end
      chk(got == d, "R6 transmitted byte", got, d);
      wr(2'd3, 8'h00); wr(2'd1, 8'd14); wr(2'd2, 8'h02);
      m_bit(1'b1, r);
      chk(ovf_flag_o && count_q == 0, "R5 nack overflow", {ovf_flag_o, count_q}, 8'h10);
      wr(2'd2, 8'h02);
    end else begin
      wr(2'd3, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h02);
      chk(!sda_low_o, "R6 disabled output", sda_low_o, 0);
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      chk(shift_q == d, "R3 data byte", shift_q, d);
      slave_ack();
      wr(2'd3, 8'h00); wr(2'd2, 8'h02);
      chk(!sda_low_o && !scl_low_o, "R6 released after ack", {sda_low_o, scl_low_o}, 0);
    end
    m_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2417));
    idle(3);
    chk(!scl_low_o && !sda_low_o, "R9 drivers", {scl_low_o, sda_low_o}, 0);
    chk(!start_flag_o && !ovf_flag_o && !stop_flag_o && !irq_o, "R9 flags",
        {start_flag_o, ovf_flag_o, stop_flag_o, irq_o}, 0);
    chk(shift_q == 0 && count_q == 0, "R9 registers", {shift_q, count_q}, 0);
    rst_n = 1'b1;
    idle(4);

    sda_m = 1'b0; idle(6);
    chk(start_flag_o, "R1 start only", start_flag_o, 1);
    sda_m = 1'b1; idle(6);
    chk(stop_flag_o && start_flag_o, "R7 stop after start", {stop_flag_o, start_flag_o}, 3);
    scl_m = 1'b0; idle(6);
    chk(!scl_low_o, "R7 cancelled start hold", scl_low_o, 0);
    wr(2'd2, 8'h07);
    chk(!start_flag_o && !stop_flag_o && !irq_o, "R8 w1c all",
        {start_flag_o, stop_flag_o, irq_o}, 0);
    scl_m = 1'b1; idle(6);

    transaction(8'hFF, 8'h5A);
    transaction(8'h00, 8'hA5);
    for (int k = 0; k < 6; k++)
      transaction(8'($urandom()), 8'($urandom()));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule